// File: doc/BRIEF.md
# Aligned PWM Channel

This block is one channel of a pulse-width modulator. A shared clock generator supplies a vector of single-cycle tick enables, one per prescale rate. The channel picks one of them, advances a 16-bit counter on each selected tick, and compares the counter with a duty value to produce a rectangular output. The counter runs in one of two shapes. In edge mode it ramps up and wraps. In symmetric mode it ramps up and then back down, so the same period setting gives twice the output period.

Software loads the channel through a small write port. Period and duty values written while the channel runs go into shadow registers. They reach the comparator only at the next cycle boundary, so a running waveform never shows a partial cycle. A one-cycle event flag marks each boundary. Four channels are built by instantiating this module four times on the same tick vector.

Top module: `pwm_chan`

## Requirements
- R1: After a synchronous active-low reset, the counter reads 0, the output and the event flag are low, the mode is edge mode with low start level and tick select 0, and both the active and the shadow period and duty values are 0.
- R2: The counter changes only on cycles where the selected tick is high. The select is bits [3:0] of the mode word, and a select value of N_CLK or above selects no tick, so the counter holds.
- R3: In edge mode (mode bit 8 = 0) with active period P > 0, the counter steps 0, 1, … P−1 on successive ticks and then returns to 0, a cycle of P ticks.
- R4: In symmetric mode (mode bit 8 = 1) with active period P > 0, the counter steps 0 up to P and back down to 1, then reaches 0 again, a cycle of 2·P ticks.
- R5: While running, the output equals the start level (mode bit 9) when the counter is below the active duty value, and its inverse otherwise. In symmetric mode the output therefore returns to the start level when the down-ramp falls below the duty value.
- R6: Writes to address 1 (period) and address 2 (duty) update only the shadow registers. The active values take the shadow values only at a cycle boundary. A write to address 3 changes nothing.
- R7: The event flag is high for exactly the one clock cycle in which the counter first shows 0 after a boundary, and is low at all other times.
- R8: With an active period of 0, the counter holds at 0, the output holds at the start level, and no event is raised. The shadow values are copied to the active values on every clock.
- R9: A duty of 0 keeps a running output at the inverse of the start level. In edge mode, a duty of P or more keeps the output at the start level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | N_CLK (13) | Tick enables from the shared clock generator |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 mode, 1 period, 2 duty, 3 unused |
| wr_data_i | input | CNT_W (16) | Write data |
| pwm_o | output | 1 | PWM waveform |
| period_evt_o | output | 1 | One-cycle cycle-boundary event |
| cnt_o | output | CNT_W (16) | Current counter value |

## Verification
A bad counter value or a bad count direction shows up on cnt_o on the very next selected tick. It also shows up on pwm_o as soon as the value crosses the duty threshold. An active period or duty value loaded at the wrong time, outside a boundary, puts the waveform edges in the wrong place within the same cycle. A missed or extra boundary moves period_evt_o and the counter wrap, and the reference model sees this on the clock where it happens, because cnt_o, pwm_o and the event are compared on every clock.

// File: rtl/pwm_chan_pkg.sv
// Shared definitions for the PWM channel: write addresses and the bit
// positions of the fields inside the mode word.
package pwm_chan_pkg;

    typedef enum logic [1:0] {
        ADDR_MODE   = 2'd0,
        ADDR_PERIOD = 2'd1,
        ADDR_DUTY   = 2'd2,
        ADDR_SPARE  = 2'd3
    } pwm_addr_e;

    localparam int MODE_SEL_LSB = 0;
    localparam int MODE_SYM_BIT = 8;
    localparam int MODE_POL_BIT = 9;

endpackage

// File: rtl/pwm_regs.sv
// Register file of one PWM channel. It holds the mode fields, the shadow
// period and duty values, and the active values the counter uses.
// Assumes load_i comes from the counter and is high only on a cycle boundary
// or while the channel is stopped.
module pwm_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             load_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             sym_o,
    output logic             pol_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] duty_o
);

    logic [CNT_W-1:0] per_sh, duty_sh;

    // Shadow and mode writes, plus the shadow-to-active transfer on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o   <= '0;
            sym_o   <= 1'b0;
            pol_o   <= 1'b0;
            per_sh  <= '0;
            duty_sh <= '0;
            per_o   <= '0;
            duty_o  <= '0;
        end else begin
            if (load_i) begin
                per_o  <= per_sh;
                duty_o <= duty_sh;
            end
            if (wr_en_i) begin
                case (pwm_addr_e'(wr_addr_i))
                    ADDR_MODE: begin
                        sel_o <= wr_data_i[MODE_SEL_LSB +: SEL_W];
                        sym_o <= wr_data_i[MODE_SYM_BIT];
                        pol_o <= wr_data_i[MODE_POL_BIT];
                    end
                    ADDR_PERIOD: per_sh  <= wr_data_i;
                    ADDR_DUTY:   duty_sh <= wr_data_i;
                    default: ;
                endcase
            end
        end
    end

    // R6: active duty only moves on a load.
    p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(duty_o));
    // R6: active period only moves on a load.
    p_per_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(per_o));

endmodule

// File: rtl/pwm_clk_sel.sv
// Tick selector: passes the tick enable chosen by sel_i. A select value
// outside the tick vector yields no tick. Purely combinational.
module pwm_clk_sel #(
    parameter int N_CLK = 13,
    parameter int SEL_W = 4
) (
    input  logic [N_CLK-1:0] tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    // Decode the select against each tick line.
    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < N_CLK; i++) begin
            if (sel_i == SEL_W'(i)) tick_o = tick_i[i];
        end
    end

endmodule

// File: rtl/pwm_counter.sv
// Channel counter. It ramps up and wraps in edge mode, and ramps up and
// down in symmetric mode. It flags cycle boundaries, and asks the register
// file to load the shadow values on a boundary or while the period is 0.
// Assumes tick_i is a single-cycle enable.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sym_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_o,
    output logic             load_o
);

    logic [CNT_W-1:0] cnt_nxt;
    logic             down_q, down_nxt, bnd, stopped;

    assign stopped = (per_i == '0);

    // Next count, next direction and boundary detection.
    always_comb begin
        cnt_nxt  = cnt_o;
        down_nxt = down_q;
        bnd      = 1'b0;
        if (stopped) begin
            cnt_nxt  = '0;
            down_nxt = 1'b0;
        end else if (!sym_i) begin
            down_nxt = 1'b0;
            if (cnt_o >= per_i - 1'b1) begin
                cnt_nxt = '0;
                bnd     = 1'b1;
            end else begin
                cnt_nxt = cnt_o + 1'b1;
            end
        end else if (!down_q && cnt_o < per_i) begin
            cnt_nxt = cnt_o + 1'b1;
        end else if (cnt_o <= 1) begin
            cnt_nxt  = '0;
            down_nxt = 1'b0;
            bnd      = 1'b1;
        end else begin
            cnt_nxt  = cnt_o - 1'b1;
            down_nxt = 1'b1;
        end
    end

    assign load_o = stopped | (tick_i & bnd);

    // Counter, direction and event registers, advanced on the selected tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            down_q <= 1'b0;
            evt_o  <= 1'b0;
        end else begin
            evt_o <= tick_i & bnd & ~stopped;
            if (tick_i || stopped) begin
                cnt_o  <= cnt_nxt;
                down_q <= down_nxt;
            end
        end
    end

    // R2: without a tick the count holds.
    p_cnt_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
    // R4: the count never exceeds a nonzero active period.
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_i != '0) |-> (cnt_o <= per_i));
    // R7: the event only appears with the count at 0.
    p_evt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (cnt_o == '0));
    // R8: a stopped channel stays at 0 and raises no event.
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(per_i == '0) && (per_i == '0) |-> (cnt_o == '0) && !evt_o);

endmodule

// File: rtl/pwm_compare.sv
// Comparator: drives the waveform from the count, the active duty and the
// start level. A stopped channel rests at the start level.
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic             pol_i,
    output logic             pwm_o
);

    // Level select against the duty threshold.
    always_comb begin
        if (per_i == '0)          pwm_o = pol_i;
        else if (cnt_i < duty_i)  pwm_o = pol_i;
        else                      pwm_o = ~pol_i;
    end

endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: tick selector, counter, comparator and register file.
// Assumes tick_i comes from a shared generator, with each bit a
// single-cycle enable. Four channels share one generator.
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CLK = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CLK-1:0] tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             pwm_o,
    output logic             period_evt_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int SEL_W = (N_CLK < 16) ? 4 : $clog2(N_CLK + 1);

    logic [SEL_W-1:0] sel;
    logic             sym, pol, tick, load;
    logic [CNT_W-1:0] per, duty;

    pwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .load_i(load), .sel_o(sel), .sym_o(sym),
        .pol_o(pol), .per_o(per), .duty_o(duty)
    );

    pwm_clk_sel #(.N_CLK(N_CLK), .SEL_W(SEL_W)) u_sel (
        .tick_i(tick_i), .sel_i(sel), .tick_o(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sym_i(sym), .per_i(per),
        .cnt_o(cnt_o), .evt_o(period_evt_o), .load_o(load)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .cnt_i(cnt_o), .duty_i(duty), .per_i(per), .pol_i(pol), .pwm_o(pwm_o)
    );

endmodule

// File: tb/pwm_chan_test.sv
`timescale 1ns/1ps
module pwm_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] tick_i = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm, evt;
    logic [15:0] cnt;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // reference model state
    int m_phase = 0, m_per = 0, m_duty = 0, m_pbuf = 0, m_dbuf = 0, m_sel = 0;
    bit m_sym = 0, m_pol = 0, m_evt = 0;

    pwm_chan uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm),
        .period_evt_o(evt), .cnt_o(cnt)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int exp_cnt();
        if (m_sym && m_phase > m_per) return 2 * m_per - m_phase;
        return m_phase;
    endfunction

    function automatic bit exp_pwm();
        if (m_per == 0) return m_pol;
        return (exp_cnt() < m_duty) ? m_pol : !m_pol;
    endfunction

    // reference model: one cycle phase of length P or 2P per boundary
    always @(posedge clk) begin
        bit t;
        int len;
        if (!rst_n) begin
            m_phase = 0; m_per = 0; m_duty = 0; m_pbuf = 0; m_dbuf = 0;
            m_sel = 0; m_sym = 0; m_pol = 0; m_evt = 0;
        end else begin
            t = (m_sel < 13) ? tick_i[m_sel] : 1'b0;
            m_evt = 0;
            if (m_per == 0) begin
                m_per = m_pbuf; m_duty = m_dbuf; m_phase = 0;
            end else if (t) begin
                len = m_sym ? 2 * m_per : m_per;
                m_phase++;
                if (m_phase >= len) begin
                    m_phase = 0; m_evt = 1; m_per = m_pbuf; m_duty = m_dbuf;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_sel = wr_data[3:0]; m_sym = wr_data[8]; m_pol = wr_data[9]; end
                    2'd1: m_pbuf = wr_data;
                    2'd2: m_dbuf = wr_data;
                    default: ;
                endcase
            end
        end
    end

    // tick generator and per-clock comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk("R2 R3 R4 count", cnt, exp_cnt());
            chk("R5 R6 R9 output", pwm, exp_pwm());
            chk("R7 R8 event", evt, m_evt);
        end
        for (int k = 0; k < 11; k++) tick_i[k] <= (cyc % (1 << k)) == 0;
        tick_i[11] <= (cyc % 3) == 0;
        tick_i[12] <= (cyc % 5) == 0;
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = a[1:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int hold;
        run(3);
        // R1 reset state
        chk("R1 count", cnt, 0);
        chk("R1 output", pwm, 0);
        chk("R1 event", evt, 0);
        rst_n = 1;
        run(4);
        chk("R1 idle count", cnt, 0);
        wr(0, 16'h0200);                 // edge mode, start high, tick 0
        run(3);
        chk("R8 stopped output", pwm, 1);
        chk("R8 stopped count", cnt, 0);
        wr(1, 5); wr(2, 2);
        run(40);
        wr(2, 4);                        // R6 mid-cycle duty change
        run(30);
        wr(3, 16'h0007);                 // R6 spare address ignored
        run(20);
        wr(0, 16'h0202);                 // tick every 4 cycles
        run(60);
        wr(0, 16'h020F);                 // R2 invalid select
        run(2);
        hold = cnt;
        run(20);
        chk("R2 held count", cnt, hold);
        chk("R2 no event", evt, 0);
        wr(0, 16'h000B);                 // tick every 3, start low
        run(40);
        wr(2, 0);                        // R9 duty 0
        run(40);
        wr(2, 9);                        // R9 duty above period
        run(40);
        wr(1, 0);                        // stop
        run(40);
        chk("R8 stop count", cnt, 0);
        chk("R8 stop output", pwm, 0);
        wr(0, 16'h0101);                 // symmetric, tick every 2
        wr(1, 4); wr(2, 2);
        run(80);
        wr(1, 3); wr(2, 1);              // R6 buffered period in symmetric mode
        run(60);
        wr(0, 16'h0300);                 // symmetric, start high, every cycle
        run(40);
        wr(1, 1); wr(2, 1);
        run(30);
        wr(1, 0);
        run(20);
        chk("R8 final stop", cnt, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog cycle %0d actual 0 expected 1", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule